// File: doc/BRIEF.md
# SHA3-256 Multi-Block Absorb Assembler

This block turns a byte message held in an external memory into the sequence of 136-byte rate blocks that a SHA3-256 sponge absorbs. The message length is given at start time and may be any value that fits the length port. Typical lengths are 800, 1184 and 1568 bytes. The block reads the message one byte per cycle from a memory with a one-cycle registered read. It places each byte in a 1088-bit block register and inserts the SHA-3 padding in the final block. Each finished block is then offered to a permutation engine.

Timing follows the registered memory. The address for byte `n` is issued one cycle before that byte is stored. A write-back stage holds the slot index and the padding decision for that one cycle. A fill therefore takes 137 cycles, one more than the number of bytes, so the last byte in flight is flushed. The downstream engine accepts a block by pulling its ready low while valid is high. It signals that the permutation is finished by raising ready again, and only then is the next block assembled. A one-cycle done pulse follows acceptance of the final block, so the digest can be captured.

Top module: `absorb_assembler`

## Requirements
- R1: A start pulse in idle captures the length. The message is then read in strictly increasing address order, exactly once per byte, from address 0 to length-1, with no read at or beyond the length. Read data is taken to arrive one cycle after its address.
- R2: The number of blocks offered is floor((length+136)/136). In block k, byte j sits at data bits 8j+7..8j (byte 0 in bits 7..0) and holds message byte 136k+j whenever that index is below the length.
- R3: In the final block, the byte at index length-136k equals 0x06 and byte 135 has 0x80 ORed in. If both land on byte 135 it reads 0x86. Every other byte past the message end is 0x00, and non-final blocks carry no padding.
- R4: When the length is a multiple of 136, an extra final block is emitted. Its byte 0 is 0x06, its byte 135 is 0x80, and all other bytes are zero.
- R5: Once a block is valid, valid stays high and the data stays unchanged while ready is high. A cycle in which ready is low with valid high accepts the block, and valid is low from the following cycle.
- R6: After a non-final block is accepted, no block is offered while ready stays low.
- R7: The last flag is high only together with valid, and only on the final block.
- R8: The cycle after the final block is accepted, done is high for exactly that cycle and busy is low.
- R9: A start pulse while busy is ignored. The running message keeps its length and its block contents.
- R10: After reset, valid, last, done, busy and the memory read enable are all low, including a reset applied in the middle of a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a message (sampled in idle only) |
| len_i | input | LEN_W | Message length in bytes |
| busy_o | output | 1 | A message is being processed |
| mem_en_o | output | 1 | Read enable to the message memory |
| mem_addr_o | output | LEN_W | Byte address to the message memory |
| mem_rdata_i | input | 8 | Byte returned one cycle after its address |
| blk_valid_o | output | 1 | A complete rate block is offered |
| blk_last_o | output | 1 | The offered block is the final one |
| blk_data_o | output | 1088 | Rate block, byte 0 in the low bits |
| blk_ready_i | input | 1 | Low accepts the block; high again when the permutation is finished |
| done_o | output | 1 | One-cycle pulse after the final block is accepted |

## Verification
An off-by-one in the byte counter or in the write-back stage shows up as a block whose bytes are shifted by one slot or whose byte 135 is stale. The bench sees this at the first offered block, 137 cycles after start. A wrong remainder or block base misplaces the 0x06 marker or changes the block count, and this is visible only when the final block or the quiet period after it is observed. A broken handshake shows within one cycle of ready falling, as valid still high or a missing or early done pulse. A length captured while busy changes the content of the next block.

// File: rtl/absorb_pkg.sv
package absorb_pkg;

    localparam int RATE_BYTES = 136;
    localparam int IDX_W      = $clog2(RATE_BYTES + 1);
    localparam logic [7:0] PAD_DOMAIN = 8'h06;
    localparam logic [7:0] PAD_TAIL   = 8'h80;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_OFFER,
        ST_WAIT
    } abs_state_e;

    // One write-back request: which slot, and whether it takes the memory byte or a pad byte
    typedef struct packed {
        logic             en;
        logic             from_mem;
        logic [IDX_W-1:0] idx;
        logic [7:0]       pad;
    } wb_req_t;

    function automatic logic [7:0] pad_byte(input logic at_end, input logic at_tail);
        return (at_end ? PAD_DOMAIN : 8'h00) | (at_tail ? PAD_TAIL : 8'h00);
    endfunction

endpackage

// File: rtl/absorb_seq.sv
module absorb_seq
    import absorb_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             blk_ready_i,
    output logic             mem_en_o,
    output logic [LEN_W-1:0] mem_addr_o,
    output wb_req_t          wb_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam logic [IDX_W-1:0] CNT_END  = IDX_W'(RATE_BYTES);
    localparam logic [IDX_W-1:0] CNT_TAIL = IDX_W'(RATE_BYTES - 1);
    localparam logic [LEN_W-1:0] RATE_L   = LEN_W'(RATE_BYTES);

    abs_state_e       state_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] base_q;
    logic [IDX_W-1:0] cnt_q;
    wb_req_t          wb_q;
    logic             done_q;

    logic [LEN_W-1:0] remain;
    logic [LEN_W-1:0] cnt_l;
    logic             is_last;
    logic             issue;
    logic             in_msg;

    assign remain  = len_q - base_q;
    assign cnt_l   = LEN_W'(cnt_q);
    assign is_last = remain < RATE_L;
    assign issue   = (state_q == ST_FILL) && (cnt_q < CNT_END);
    assign in_msg  = cnt_l < remain;

    assign mem_en_o   = issue && in_msg;
    assign mem_addr_o = base_q + cnt_l;
    assign wb_o       = wb_q;
    assign valid_o    = (state_q == ST_OFFER);
    assign last_o     = valid_o && is_last;
    assign done_o     = done_q;
    assign busy_o     = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            wb_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q      <= 1'b0;
            wb_q.en       <= issue;
            wb_q.from_mem <= in_msg;
            wb_q.idx      <= cnt_q;
            wb_q.pad      <= pad_byte(cnt_l == remain, is_last && (cnt_q == CNT_TAIL));
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        len_q   <= len_i;
                        base_q  <= '0;
                        cnt_q   <= '0;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (cnt_q == CNT_END) state_q <= ST_OFFER;
                    else                  cnt_q   <= cnt_q + 1'b1;
                end
                ST_OFFER: begin
                    if (!blk_ready_i) begin
                        if (is_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (blk_ready_i) begin
                        base_q  <= base_q + RATE_L;
                        cnt_q   <= '0;
                        state_q <= ST_FILL;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: the fill counter never passes the flush slot
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |-> (cnt_q <= CNT_END));

    // R1: no read at or past the message end
    p_addr_in_msg_r1: assert property (@(posedge clk) disable iff (rst)
        mem_en_o |-> (mem_addr_o < len_q));

    // R9: a start while busy leaves the captured length alone
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (len_q == $past(len_q)));

    // R8: done only after the final block was accepted
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(valid_o && last_o && !blk_ready_i));

endmodule

// File: rtl/absorb_blkreg.sv
module absorb_blkreg
    import absorb_pkg::*;
#(
    parameter int BLK_W = RATE_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  wb_req_t          wb_i,
    input  logic [7:0]       mem_rdata_i,
    output logic [BLK_W-1:0] blk_o
);

    for (genvar j = 0; j < RATE_BYTES; j++) begin : g_slot
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (wb_i.en && (wb_i.idx == IDX_W'(j)))
                byte_q <= wb_i.from_mem ? mem_rdata_i : wb_i.pad;
        end
        assign blk_o[j*8 +: 8] = byte_q;
    end

    // R2: write-back only addresses an existing slot
    p_wb_slot_r2: assert property (@(posedge clk) disable iff (rst)
        wb_i.en |-> (wb_i.idx < IDX_W'(RATE_BYTES)));

endmodule

// File: rtl/absorb_assembler.sv
module absorb_assembler
    import absorb_pkg::*;
#(
    parameter int LEN_W = 11,
    localparam int BLK_W = RATE_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             mem_en_o,
    output logic [LEN_W-1:0] mem_addr_o,
    input  logic [7:0]       mem_rdata_i,
    output logic             blk_valid_o,
    output logic             blk_last_o,
    output logic [BLK_W-1:0] blk_data_o,
    input  logic             blk_ready_i,
    output logic             done_o
);

    wb_req_t wb;

    absorb_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .len_i       (len_i),
        .blk_ready_i (blk_ready_i),
        .mem_en_o    (mem_en_o),
        .mem_addr_o  (mem_addr_o),
        .wb_o        (wb),
        .valid_o     (blk_valid_o),
        .last_o      (blk_last_o),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    absorb_blkreg #(.BLK_W(BLK_W)) u_blk (
        .clk         (clk),
        .rst         (rst),
        .wb_i        (wb),
        .mem_rdata_i (mem_rdata_i),
        .blk_o       (blk_data_o)
    );

    // R5: an offered block stays put while ready is high
    p_hold_block_r5: assert property (@(posedge clk) disable iff (rst)
        (blk_valid_o && blk_ready_i) |=> (blk_valid_o && $stable(blk_data_o)));

    // R5: acceptance withdraws the block on the next cycle
    p_accept_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (blk_valid_o && !blk_ready_i) |=> !blk_valid_o);

    // R7: last never appears without valid
    p_last_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        blk_last_o |-> blk_valid_o);

endmodule

// File: tb/test_absorb_assembler.sv
module test_absorb_assembler;

    localparam int LEN_W = 11;
    localparam int RB    = 136;
    localparam int BW    = RB * 8;

    localparam int NVEC = 7;
    localparam int VEC_LEN  [NVEC] = '{800, 1184, 1568, 136, 135, 1, 272};
    localparam int VEC_NBLK [NVEC] = '{6,   9,    12,   2,   1,   1, 3};
    localparam bit VEC_POKE [NVEC] = '{0,   0,    0,    0,   0,   0, 1};

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i;
    logic [LEN_W-1:0] len_i;
    logic             busy_o;
    logic             mem_en_o;
    logic [LEN_W-1:0] mem_addr_o;
    logic [7:0]       mem_rdata_i;
    logic             blk_valid_o;
    logic             blk_last_o;
    logic [BW-1:0]    blk_data_o;
    logic             blk_ready_i;
    logic             done_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [BW-1:0] last_blk;

    always #10 clk = ~clk;

    absorb_assembler #(.LEN_W(LEN_W)) i_absorb_assembler (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
        .busy_o(busy_o), .mem_en_o(mem_en_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .blk_valid_o(blk_valid_o),
        .blk_last_o(blk_last_o), .blk_data_o(blk_data_o),
        .blk_ready_i(blk_ready_i), .done_o(done_o)
    );

    function automatic logic [7:0] msg_byte(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    // message memory with registered read
    always @(posedge clk) mem_rdata_i <= msg_byte(int'(mem_addr_o));

    // read-order monitor
    int mon_reads = 0;
    int mon_bad   = 0;
    int mon_prev  = 0;
    always @(negedge clk) begin
        if (mem_en_o) begin
            if (int'(mem_addr_o) != 0 && int'(mem_addr_o) != mon_prev + 1) mon_bad++;
            mon_prev = int'(mem_addr_o);
            mon_reads++;
        end
    end

    function automatic logic [BW-1:0] exp_block(input int len, input int k, input int nb);
        logic [BW-1:0] r;
        for (int j = 0; j < RB; j++) begin
            int g = k * RB + j;
            logic [7:0] b;
            b = (g < len) ? msg_byte(g) : 8'h00;
            if (g == len) b = b | 8'h06;
            if (k == nb - 1 && j == RB - 1) b = b | 8'h80;
            r[j*8 +: 8] = b;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_msg(input int len, input int nb, input bit poke);
        int reads0 = mon_reads;
        int bad0   = mon_bad;
        bit extra  = 0;
        @(negedge clk);
        start_i = 1'b1;
        len_i   = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
        len_i   = '0;
        if (poke) begin
            // R9: a second start with another length while busy
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            len_i   = LEN_W'(1);
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int k = 0; k < nb; k++) begin
            int w = 0;
            bit hold_ok = 1;
            bit low_ok = 1;
            int diff = -1;
            logic [BW-1:0] snap;
            logic [BW-1:0] ex;
            while (!blk_valid_o && w < 400) begin
                @(negedge clk);
                w++;
            end
            chk(blk_valid_o, "R2 block offered", 64'(blk_valid_o), 64'd1);
            snap = blk_data_o;
            chk(blk_last_o == (k == nb - 1), "R7 last flag", 64'(blk_last_o), 64'(k == nb - 1));
            repeat (3) begin
                @(negedge clk);
                if (!blk_valid_o || blk_data_o != snap) hold_ok = 0;
            end
            chk(hold_ok, "R5 hold while ready high", 64'(hold_ok), 64'd1);
            ex = exp_block(len, k, nb);
            for (int j = RB - 1; j >= 0; j--)
                if (snap[j*8 +: 8] != ex[j*8 +: 8]) diff = j;
            chk(diff < 0, $sformatf("R2/R3 len %0d block %0d byte %0d", len, k, diff),
                diff < 0 ? 64'd0 : 64'(snap[diff*8 +: 8]),
                diff < 0 ? 64'd0 : 64'(ex[diff*8 +: 8]));
            last_blk = snap;
            blk_ready_i = 1'b0;
            @(negedge clk);
            chk(!blk_valid_o, "R5 accept drops valid", 64'(blk_valid_o), 64'd0);
            if (k == nb - 1) begin
                chk(done_o, "R8 done pulse", 64'(done_o), 64'd1);
                chk(!busy_o, "R8 busy low", 64'(busy_o), 64'd0);
                blk_ready_i = 1'b1;
                @(negedge clk);
                chk(!done_o, "R8 done one cycle", 64'(done_o), 64'd0);
            end else begin
                chk(!done_o, "R8 no early done", 64'(done_o), 64'd0);
                repeat (10) begin
                    @(negedge clk);
                    if (blk_valid_o) low_ok = 0;
                end
                chk(low_ok, "R6 wait for ready", 64'(low_ok), 64'd1);
                blk_ready_i = 1'b1;
            end
        end
        repeat (300) begin
            @(negedge clk);
            if (blk_valid_o) extra = 1;
        end
        chk(!extra, "R2 block count", 64'(extra), 64'd0);
        chk(mon_reads - reads0 == len, "R1 read count", 64'(mon_reads - reads0), 64'(len));
        chk(mon_bad == bad0, "R1 read order", 64'(mon_bad - bad0), 64'd0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        len_i = '0;
        blk_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(!blk_valid_o, "R10 valid after reset", 64'(blk_valid_o), 64'd0);
        chk(!blk_last_o, "R10 last after reset", 64'(blk_last_o), 64'd0);
        chk(!done_o, "R10 done after reset", 64'(done_o), 64'd0);
        chk(!busy_o, "R10 busy after reset", 64'(busy_o), 64'd0);
        chk(!mem_en_o, "R10 read enable after reset", 64'(mem_en_o), 64'd0);

        for (int v = 0; v < NVEC; v++) begin
            chk(VEC_NBLK[v] == (VEC_LEN[v] + RB) / RB, "R2 table count", 64'(VEC_NBLK[v]),
                64'((VEC_LEN[v] + RB) / RB));
            run_msg(VEC_LEN[v], VEC_NBLK[v], VEC_POKE[v]);
            if (VEC_LEN[v] == 135) begin
                // R3: domain and tail bits share byte 135
                chk(last_blk[135*8 +: 8] == 8'h86, "R3 coincident pad", 64'(last_blk[135*8 +: 8]), 64'h86);
            end
            if (VEC_LEN[v] == 136) begin
                bit zeros = 1;
                for (int j = 1; j < RB - 1; j++) if (last_blk[j*8 +: 8] != 8'h00) zeros = 0;
                chk(last_blk[7:0] == 8'h06, "R4 pad-only first byte", 64'(last_blk[7:0]), 64'h06);
                chk(last_blk[135*8 +: 8] == 8'h80, "R4 pad-only tail byte", 64'(last_blk[135*8 +: 8]), 64'h80);
                chk(zeros, "R4 pad-only middle", 64'(zeros), 64'd1);
            end
        end

        // R10: reset in the middle of a message
        @(negedge clk);
        start_i = 1'b1;
        len_i = LEN_W'(800);
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy_o, "R10 busy after mid reset", 64'(busy_o), 64'd0);
        chk(!mem_en_o, "R10 read enable after mid reset", 64'(mem_en_o), 64'd0);
        chk(!blk_valid_o, "R10 valid after mid reset", 64'(blk_valid_o), 64'd0);
        run_msg(1, 1, 1'b0);

        finish_run();
    end

endmodule